// File: doc/BRIEF.md
# Signed Vector Element Move Unit

This unit decodes and executes one instruction: it takes a signed integer element out of a 128-bit vector register value and hands it back, sign-extended, for a general-purpose register write. Each cycle it may receive a 32-bit instruction word with a valid strobe, a SIMD-feature enable and the 128-bit contents of the source vector register. A single five-bit immediate carries both the element size and the element index, using a lowest-set-bit code. The unit checks that the word carries this instruction's fixed opcode bits, rejects illegal encodings, picks out the element, sign-extends it to 32 or 64 bits and reports which enable check the surrounding pipeline must apply.

A small state machine describes the output side. It has three states. IDLE means no result is shown. RESULT means a matched instruction was taken on the previous edge. REJECT means the previous word did not match. It has three transitions, all taken from any state at each clock edge. The accept transition (valid and matched) goes to RESULT. The reject transition (valid and not matched) goes to REJECT. The quiet transition (no valid input) goes to IDLE. The latency is always one clock, whatever the data values.

Top module: `sxmov_unit`

## Requirements
- R1: A word matches only when bit 31 is 0, bits 29..21 are 001110000 and bits 15..10 are 001011. A valid word that does not match raises out_nomatch one clock later. In that clock out_valid stays low and out_rd, out_vn and out_data keep their previous values.
- R2: One clock after a valid matched word, out_valid is high for that single clock. In any clock after a cycle with in_valid low, both out_valid and out_nomatch are low.
- R3: When immediate bits [2:0] (word bits 18..16) are all zero, the result is flagged undefined.
- R4: When simd_en is low, every matched word is flagged undefined.
- R5: A word element (imm[2:0]=100) with Q (bit 30) equal to 0 is undefined. For an undefined result, out_valid=1, out_undef=1, out_data=0 and out_chk_simd=0.
- R6: Byte element (imm[0]=1): the index is imm[4:1] and the element is source bits [8*index+7 : 8*index].
- R7: Halfword element (imm[1:0]=10): the index is imm[4:2] and the element is source bits [16*index+15 : 16*index].
- R8: Word element (imm[2:0]=100, Q=1): the index is imm[4:3] and the element is source bits [32*index+31 : 32*index].
- R9: The element is sign-extended to 32 bits when Q=0, with out_data[63:32] set to 0, and to 64 bits when Q=1.
- R10: out_chk_simd is 0 (scalar floating-point enable check) when the index is zero and 1 (combined floating-point/SIMD check) otherwise.
- R11: A synchronous active-high reset clears every output to 0.
- R12: out_rd carries word bits 4..0, out_vn carries bits 9..5 and out_wide carries Q, all from the last matched word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word present |
| instr | input | 32 | Instruction word |
| simd_en | input | 1 | SIMD feature implemented/enabled |
| vec_src | input | 128 | Source vector register contents |
| out_valid | output | 1 | Matched instruction result present |
| out_nomatch | output | 1 | Previous valid word was not this instruction |
| out_undef | output | 1 | Encoding undefined |
| out_chk_simd | output | 1 | 1: combined FP/SIMD check, 0: scalar FP check |
| out_wide | output | 1 | Destination is 64 bits |
| out_rd | output | 5 | Destination general register number |
| out_vn | output | 5 | Source vector register number |
| out_data | output | 64 | Sign-extended result |

## Verification
The hardest situation to reach is a rejected word arriving straight after a good result. It must raise out_nomatch while leaving the earlier destination and data on the outputs. The stimulus therefore issues a legal move and then, without an idle cycle in between, a word that differs from it only in one fixed opcode bit and carries a different destination number and immediate. The bench then checks that the earlier destination and data survive. The edge indices of each element size, both signs of the top element bit, and the three distinct ways to reach the undefined state are also reached through a vector table.

// File: rtl/sxmov_pkg.sv
package sxmov_pkg;

    localparam int INSTR_W   = 32;
    localparam int RES_W     = 64;
    localparam int IMM_W     = 5;
    localparam int REG_W     = 5;
    localparam int IDX_W     = 4;

    localparam logic [8:0] OPC_HI = 9'b001110000;
    localparam logic [5:0] OPC_LO = 6'b001011;

    typedef enum logic [1:0] {
        SZ_B = 2'd0,
        SZ_H = 2'd1,
        SZ_W = 2'd2
    } esz_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RESULT = 2'd1,
        ST_REJECT = 2'd2
    } st_t;

    typedef struct packed {
        logic             hit;
        logic             undef;
        logic             wide;
        esz_t             sz;
        logic [IDX_W-1:0] idx;
        logic [REG_W-1:0] rd;
        logic [REG_W-1:0] vn;
        logic             chk;
    } dec_t;

endpackage

// File: rtl/sxmov_decode.sv
module sxmov_decode
    import sxmov_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    input  logic               simd_en,
    output dec_t               dec
);

    logic [IMM_W-1:0] imm;
    esz_t             sz;
    logic [IDX_W-1:0] idx;
    logic             bad;

    assign imm = instr[20:16];

    always_comb begin
        if (imm[0]) begin
            sz = SZ_B;
        end else if (imm[1]) begin
            sz = SZ_H;
        end else begin
            sz = SZ_W;
        end
    end

    always_comb begin
        unique case (sz)
            SZ_B:    idx = imm[4:1];
            SZ_H:    idx = {1'b0, imm[4:2]};
            SZ_W:    idx = {2'b00, imm[4:3]};
            default: idx = '0;
        endcase
    end

    always_comb begin
        bad = 1'b0;
        if (imm[2:0] == 3'b000) bad = 1'b1;
        if (!simd_en) bad = 1'b1;
        if (!instr[30] && sz == SZ_W) bad = 1'b1;
    end

    always_comb begin
        dec.hit   = !instr[31] && instr[29:21] == OPC_HI && instr[15:10] == OPC_LO;
        dec.undef = bad;
        dec.wide  = instr[30];
        dec.sz    = sz;
        dec.idx   = idx;
        dec.rd    = instr[4:0];
        dec.vn    = instr[9:5];
        dec.chk   = !bad && (idx != '0);
    end

endmodule

// File: rtl/sxmov_extract.sv
module sxmov_extract
    import sxmov_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic [VEC_W-1:0] vec,
    input  esz_t             sz,
    input  logic [IDX_W-1:0] idx,
    input  logic             wide,
    output logic [RES_W-1:0] data
);

    localparam int NB  = VEC_W / 8;
    localparam int NH  = VEC_W / 16;
    localparam int NW  = VEC_W / 32;
    localparam int BIW = $clog2(NB);
    localparam int HIW = $clog2(NH);
    localparam int WIW = $clog2(NW);

    logic [7:0]  b_lane [NB];
    logic [15:0] h_lane [NH];
    logic [31:0] w_lane [NW];

    for (genvar g = 0; g < NB; g++) begin : g_byte
        assign b_lane[g] = vec[g*8 +: 8];
    end
    for (genvar g = 0; g < NH; g++) begin : g_half
        assign h_lane[g] = vec[g*16 +: 16];
    end
    for (genvar g = 0; g < NW; g++) begin : g_word
        assign w_lane[g] = vec[g*32 +: 32];
    end

    logic [7:0]       b_sel;
    logic [15:0]      h_sel;
    logic [31:0]      w_sel;
    logic [RES_W-1:0] ext;

    assign b_sel = b_lane[idx[BIW-1:0]];
    assign h_sel = h_lane[idx[HIW-1:0]];
    assign w_sel = w_lane[idx[WIW-1:0]];

    always_comb begin
        unique case (sz)
            SZ_B:    ext = {{(RES_W-8){b_sel[7]}}, b_sel};
            SZ_H:    ext = {{(RES_W-16){h_sel[15]}}, h_sel};
            SZ_W:    ext = {{(RES_W-32){w_sel[31]}}, w_sel};
            default: ext = '0;
        endcase
    end

    assign data = wide ? ext : {{(RES_W-32){1'b0}}, ext[31:0]};

endmodule

// File: rtl/sxmov_ctrl.sv
module sxmov_ctrl
    import sxmov_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic hit,
    output st_t  state
);

    st_t nxt;

    always_comb begin
        unique case (state)
            ST_IDLE, ST_RESULT, ST_REJECT: begin
                if (in_valid && hit) begin
                    nxt = ST_RESULT;
                end else if (in_valid) begin
                    nxt = ST_REJECT;
                end else begin
                    nxt = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

endmodule

// File: rtl/sxmov_unit.sv
module sxmov_unit
    import sxmov_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [31:0]        instr,
    input  logic               simd_en,
    input  logic [VEC_W-1:0]   vec_src,
    output logic               out_valid,
    output logic               out_nomatch,
    output logic               out_undef,
    output logic               out_chk_simd,
    output logic               out_wide,
    output logic [4:0]         out_rd,
    output logic [4:0]         out_vn,
    output logic [63:0]        out_data
);

    dec_t             dec;
    st_t              state;
    logic [RES_W-1:0] ext_data;

    sxmov_decode u_dec (
        .instr   (instr),
        .simd_en (simd_en),
        .dec     (dec)
    );

    sxmov_extract #(.VEC_W(VEC_W)) u_ext (
        .vec  (vec_src),
        .sz   (dec.sz),
        .idx  (dec.idx),
        .wide (dec.wide),
        .data (ext_data)
    );

    sxmov_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .hit      (dec.hit),
        .state    (state)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_rd       <= '0;
            out_vn       <= '0;
            out_data     <= '0;
            out_undef    <= 1'b0;
            out_chk_simd <= 1'b0;
            out_wide     <= 1'b0;
        end else if (in_valid && dec.hit) begin
            out_rd       <= dec.rd;
            out_vn       <= dec.vn;
            out_data     <= dec.undef ? '0 : ext_data;
            out_undef    <= dec.undef;
            out_chk_simd <= dec.chk;
            out_wide     <= dec.wide;
        end
    end

    always_comb begin
        unique case (state)
            ST_RESULT: begin out_valid = 1'b1; out_nomatch = 1'b0; end
            ST_REJECT: begin out_valid = 1'b0; out_nomatch = 1'b1; end
            default:   begin out_valid = 1'b0; out_nomatch = 1'b0; end
        endcase
    end

    // R2
    accept_gives_valid_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && dec.hit |=> out_valid && !out_nomatch);

    // R1
    reject_holds_dest_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && !dec.hit |=> out_nomatch && !out_valid && $stable(out_rd) && $stable(out_data));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid && !out_nomatch);

    // R9
    narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_wide |-> out_data[63:32] == 32'd0);

    // R5
    undef_clears_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_undef |-> out_data == 64'd0 && !out_chk_simd);

endmodule

// File: tb/sxmov_unit_test.sv
module sxmov_unit_test;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [31:0]  instr = '0;
    logic         simd_en = 1'b1;
    logic [127:0] vec_src = '0;
    logic         out_valid, out_nomatch, out_undef, out_chk_simd, out_wide;
    logic [4:0]   out_rd, out_vn;
    logic [63:0]  out_data;

    int checks = 0;
    int errors = 0;

    localparam logic [127:0] VEC = 128'hF0E1D2C3_B4A59687_78695A4B_3C2D1E0F;

    // fields: q, imm5, rd, undef, chk, data
    localparam int NV = 13;
    localparam logic [76:0] TBL [NV] = '{
        {1'b0, 5'b00001, 5'd3,  1'b0, 1'b0, 64'h0000000000000000F},
        {1'b0, 5'b10001, 5'd4,  1'b0, 1'b1, 64'h00000000FFFFFF87},
        {1'b1, 5'b11111, 5'd5,  1'b0, 1'b1, 64'hFFFFFFFFFFFFFFF0},
        {1'b1, 5'b00011, 5'd6,  1'b0, 1'b1, 64'h000000000000001E},
        {1'b0, 5'b00010, 5'd7,  1'b0, 1'b0, 64'h0000000000001E0F},
        {1'b0, 5'b10110, 5'd8,  1'b0, 1'b1, 64'h00000000FFFFB4A5},
        {1'b1, 5'b11110, 5'd9,  1'b0, 1'b1, 64'hFFFFFFFFFFFFF0E1},
        {1'b1, 5'b00100, 5'd10, 1'b0, 1'b0, 64'h000000003C2D1E0F},
        {1'b1, 5'b11100, 5'd11, 1'b0, 1'b1, 64'hFFFFFFFFF0E1D2C3},
        {1'b1, 5'b01100, 5'd12, 1'b0, 1'b1, 64'h0000000078695A4B},
        {1'b0, 5'b00100, 5'd13, 1'b1, 1'b0, 64'h0000000000000000},
        {1'b1, 5'b11000, 5'd14, 1'b1, 1'b0, 64'h0000000000000000},
        {1'b0, 5'b01000, 5'd15, 1'b1, 1'b0, 64'h0000000000000000}
    };

    sxmov_unit uut (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .instr        (instr),
        .simd_en      (simd_en),
        .vec_src      (vec_src),
        .out_valid    (out_valid),
        .out_nomatch  (out_nomatch),
        .out_undef    (out_undef),
        .out_chk_simd (out_chk_simd),
        .out_wide     (out_wide),
        .out_rd       (out_rd),
        .out_vn       (out_vn),
        .out_data     (out_data)
    );

    always #4 clk = ~clk;

    function automatic logic [31:0] mk(input logic q, input logic [4:0] imm,
                                       input logic [4:0] vn, input logic [4:0] rd);
        return {1'b0, q, 9'b001110000, imm, 6'b001011, vn, rd};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive one word for one cycle; outputs are sampled at the following negedge
    task automatic issue(input logic [31:0] w);
        @(negedge clk);
        instr    = w;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #(8 * 20000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        vec_src = VEC;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 valid", {63'd0, out_valid}, 64'd0);
        chk("R11 data", out_data, 64'd0);
        chk("R11 rd", {59'd0, out_rd}, 64'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic        q;
            logic [4:0]  imm, rd;
            logic        eu, ec;
            logic [63:0] ed;
            {q, imm, rd, eu, ec, ed} = TBL[i];
            issue(mk(q, imm, 5'd17, rd));
            // R2 R6 R7 R8 R9 R3 R5 R10 R12
            chk($sformatf("R2 valid v%0d", i), {63'd0, out_valid}, 64'd1);
            chk($sformatf("R6/R7/R8/R9 data v%0d", i), out_data, ed);
            chk($sformatf("R3/R5 undef v%0d", i), {63'd0, out_undef}, {63'd0, eu});
            chk($sformatf("R10 chk v%0d", i), {63'd0, out_chk_simd}, {63'd0, ec});
            chk($sformatf("R12 rd v%0d", i), {59'd0, out_rd}, {59'd0, rd});
            chk($sformatf("R12 wide v%0d", i), {63'd0, out_wide}, {63'd0, q});
        end
        chk("R12 vn", {59'd0, out_vn}, 64'd17);

        // R2 quiet cycle after a result
        @(negedge clk);
        chk("R2 idle valid", {63'd0, out_valid}, 64'd0);
        chk("R2 idle nomatch", {63'd0, out_nomatch}, 64'd0);

        // R4 feature disabled
        simd_en = 1'b0;
        issue(mk(1'b1, 5'b00011, 5'd1, 5'd20));
        chk("R4 undef", {63'd0, out_undef}, 64'd1);
        chk("R4 data", out_data, 64'd0);
        simd_en = 1'b1;

        // R1 rejected word directly after a good one
        vec_src = 128'h80 << 40;
        @(negedge clk);
        instr    = mk(1'b1, 5'b01011, 5'd2, 5'd21);
        in_valid = 1'b1;
        @(negedge clk);
        chk("R9 top sign", out_data, 64'hFFFFFFFFFFFFFF80);
        instr = mk(1'b1, 5'b00001, 5'd3, 5'd22) ^ 32'h0000_0400;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1 nomatch", {63'd0, out_nomatch}, 64'd1);
        chk("R1 valid low", {63'd0, out_valid}, 64'd0);
        chk("R1 rd held", {59'd0, out_rd}, 64'd21);
        chk("R1 vn held", {59'd0, out_vn}, 64'd2);
        chk("R1 data held", out_data, 64'hFFFFFFFFFFFFFF80);

        // R1 bit 31 set is not a match
        issue(mk(1'b0, 5'b00001, 5'd3, 5'd23) | 32'h8000_0000);
        chk("R1 bit31 nomatch", {63'd0, out_nomatch}, 64'd1);

        // R11 reset after activity
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R11 data after", out_data, 64'd0);
        chk("R11 rd after", {59'd0, out_rd}, 64'd0);
        chk("R11 wide after", {63'd0, out_wide}, 64'd0);
        rst = 1'b0;
        @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule